// File: doc/BRIEF.md
# Pointer-Selectable Scratchpad Register File

This block holds the sixteen 16-bit general registers of a small processor whose accumulator and ALU are one byte wide. All traffic between a register and the accumulator moves one half at a time. Copying one register into another therefore takes four byte operations. Two internal 4-bit selectors decide which register acts as the program counter and which acts as the data pointer. Either selector can name any register.

A fetch or a data-pointer access sends the selected 16-bit register out over an 8-bit address bus. The high byte goes first, with a latch strobe, and the low byte follows with its own strobe. During that time the block reports busy. A fetch always advances the program-counter register by one. A data-pointer access advances its register only when the caller asks for it. The surrounding control unit drives one operation strobe per cycle. It can also increment any register directly, and it reads bytes back on a registered output that is marked by a valid pulse.

Top module: `scratchpad_file`

## Requirements
- R1: While reset is active, and after it ends, the selectors and every register read as zero. In the idle state, `readValid`, `busy`, both address strobes, `addrOut` and `readByte` are zero, so the first fetch emits address 0x0000.
- R2: `wrHi` loads `accIn` into bits 15:8 of register `regSel`, and `wrLo` loads it into bits 7:0. The other half keeps its value.
- R3: `rdHi` or `rdLo` on a clock edge returns bits 15:8 or bits 7:0 of register `regSel` on `readByte` after that edge, with `readValid` high for exactly that one cycle. `readByte` holds its value until the next accepted read.
- R4: A `fetch` or `idxAccess` accepted at an edge is followed by two bus cycles. In the first, `addrOut` carries address bits 15:8 with `addrHiStb` high. In the second, it carries bits 7:0 with `addrLoStb` high. `busy` is high for both cycles, and `addrOut` is zero when idle.
- R5: Each fetch increments the program-counter register by one, wrapping from 0xFFFF to 0x0000. The address sent is the value before the increment.
- R6: `setPc` makes register `regSel` the program counter for later fetches.
- R7: `setIdx` makes register `regSel` the data pointer. `idxAccess` sends that register's value out, and it increments the register by one only when `idxAdvance` is high.
- R8: `incReg` increments register `regSel` by one, wrapping from 0xFFFF to 0x0000.
- R9: Every operation strobe raised while `busy` is high is ignored.
- R10: When several strobes are high in an idle cycle, only the highest-priority one takes effect. The order, from highest to lowest, is `fetch`, `idxAccess`, `wrHi`, `wrLo`, `incReg`, `rdHi`, `rdLo`, `setPc`, `setIdx`.
- R11: A whole register is copied with four byte operations: read low, write low, read high, write high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 4 | Register number for byte, increment and selector operations |
| accIn | input | 8 | Accumulator byte for writes |
| wrLo | input | 1 | Write accumulator to low half |
| wrHi | input | 1 | Write accumulator to high half |
| rdLo | input | 1 | Read low half |
| rdHi | input | 1 | Read high half |
| incReg | input | 1 | Increment the register named by `regSel` |
| setPc | input | 1 | Load the program-counter selector from `regSel` |
| setIdx | input | 1 | Load the data-pointer selector from `regSel` |
| fetch | input | 1 | Send the program counter out and advance it |
| idxAccess | input | 1 | Send the data pointer out |
| idxAdvance | input | 1 | With `idxAccess`, advance the data pointer |
| readByte | output | 8 | Registered read result |
| readValid | output | 1 | One-cycle marker of a fresh read result |
| addrOut | output | 8 | Multiplexed address byte |
| addrHiStb | output | 1 | High address byte present |
| addrLoStb | output | 1 | Low address byte present |
| busy | output | 1 | Address transfer in progress |

## Verification
The first fetches use the program counter straight after reset. Later fetches switch it to a register written by the accumulator, and then to one preset to 0xFFFF. Together these separate a correct selector from a fixed one and show the wrap. Data-pointer accesses alternate the advance flag, so that an increment applied always can be told from one applied on request. Byte writes are followed by reads of the opposite half, and a write, a read, a fetch and an increment are raised in the same cycle or while busy, which exposes a clobbered half, a broken priority order and a missing busy lockout. A four-step copy feeds each byte that was read back in as the next write.

// File: rtl/sp_pkg.sv
package sp_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_HI   = 2'd1,
    BUS_LO   = 2'd2
  } busPhase_t;

  typedef struct packed {
    logic doWrHi;
    logic doWrLo;
    logic doInc;
    logic doRdHi;
    logic doRdLo;
    logic doSetPc;
    logic doSetIdx;
    logic doCapture;
    logic capUseIdx;
    logic capAdvance;
    logic phaseHi;
    logic phaseLo;
  } spCtl_t;

endpackage

// File: rtl/sp_control.sv
module sp_control
  import sp_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   wrLo,
  input  logic   wrHi,
  input  logic   rdLo,
  input  logic   rdHi,
  input  logic   incReg,
  input  logic   setPc,
  input  logic   setIdx,
  input  logic   fetch,
  input  logic   idxAccess,
  input  logic   idxAdvance,
  output spCtl_t ctl,
  output logic   busy,
  output logic   addrHiStb,
  output logic   addrLoStb
);

  busPhase_t phase, phaseNext;
  logic idle;

  assign idle = (phase == BUS_IDLE);

  // Bus sequencer: IDLE -> HI -> LO -> IDLE.
  always_comb begin
    phaseNext = phase;
    unique case (phase)
      BUS_IDLE: if (fetch || idxAccess) phaseNext = BUS_HI;
      BUS_HI:   phaseNext = BUS_LO;
      BUS_LO:   phaseNext = BUS_IDLE;
      default:  phaseNext = BUS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= BUS_IDLE;
    else       phase <= phaseNext;
  end

  // Fixed priority decode: one operation per idle cycle.
  always_comb begin
    ctl = '0;
    if (idle) begin
      if (fetch) begin
        ctl.doCapture  = 1'b1;
        ctl.capUseIdx  = 1'b0;
        ctl.capAdvance = 1'b1;
      end else if (idxAccess) begin
        ctl.doCapture  = 1'b1;
        ctl.capUseIdx  = 1'b1;
        ctl.capAdvance = idxAdvance;
      end else if (wrHi) begin
        ctl.doWrHi = 1'b1;
      end else if (wrLo) begin
        ctl.doWrLo = 1'b1;
      end else if (incReg) begin
        ctl.doInc = 1'b1;
      end else if (rdHi) begin
        ctl.doRdHi = 1'b1;
      end else if (rdLo) begin
        ctl.doRdLo = 1'b1;
      end else if (setPc) begin
        ctl.doSetPc = 1'b1;
      end else if (setIdx) begin
        ctl.doSetIdx = 1'b1;
      end
    end
    ctl.phaseHi = (phase == BUS_HI);
    ctl.phaseLo = (phase == BUS_LO);
  end

  assign busy      = !idle;
  assign addrHiStb = (phase == BUS_HI);
  assign addrLoStb = (phase == BUS_LO);

endmodule

// File: rtl/sp_datapath.sv
module sp_datapath
  import sp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BUS_W  = 8,
  parameter int N_REGS = 16,
  parameter int SEL_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  spCtl_t           ctl,
  input  logic [SEL_W-1:0] regSel,
  input  logic [BUS_W-1:0] accIn,
  output logic [BUS_W-1:0] readByte,
  output logic             readValid,
  output logic [BUS_W-1:0] addrOut
);

  localparam int HALF_HI_LSB = ADDR_W - BUS_W;

  logic [ADDR_W-1:0] regBank [N_REGS];
  logic [SEL_W-1:0]  pcSel, idxSel, srcSel;
  logic [ADDR_W-1:0] addrLatch;
  logic [ADDR_W-1:0] selWord;

  assign srcSel  = ctl.capUseIdx ? idxSel : pcSel;
  assign selWord = regBank[regSel];

  // One storage slice per register.
  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    logic [ADDR_W-1:0] regQ;
    logic              hit;
    logic              bump;

    assign hit  = (regSel == SEL_W'(i));
    assign bump = (ctl.doCapture && ctl.capAdvance && (srcSel == SEL_W'(i)))
               || (ctl.doInc && hit);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        regQ <= '0;
      end else if (ctl.doWrHi && hit) begin
        regQ[ADDR_W-1:HALF_HI_LSB] <= accIn;
      end else if (ctl.doWrLo && hit) begin
        regQ[BUS_W-1:0] <= accIn;
      end else if (bump) begin
        regQ <= regQ + ADDR_W'(1);
      end
    end

    assign regBank[i] = regQ;
  end

  // Pointer selectors.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcSel  <= '0;
      idxSel <= '0;
    end else begin
      if (ctl.doSetPc)  pcSel  <= regSel;
      if (ctl.doSetIdx) idxSel <= regSel;
    end
  end

  // Byte read port.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      readByte  <= '0;
      readValid <= 1'b0;
    end else begin
      readValid <= ctl.doRdHi || ctl.doRdLo;
      if (ctl.doRdHi)      readByte <= selWord[ADDR_W-1:HALF_HI_LSB];
      else if (ctl.doRdLo) readByte <= selWord[BUS_W-1:0];
    end
  end

  // Address capture and byte multiplexing.
  always_ff @(posedge clk) begin
    if (!rstN)              addrLatch <= '0;
    else if (ctl.doCapture) addrLatch <= regBank[srcSel];
  end

  always_comb begin
    if (ctl.phaseHi)      addrOut = addrLatch[ADDR_W-1:HALF_HI_LSB];
    else if (ctl.phaseLo) addrOut = addrLatch[BUS_W-1:0];
    else                  addrOut = '0;
  end

endmodule

// File: rtl/scratchpad_file.sv
module scratchpad_file
  import sp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BUS_W  = 8,
  parameter int N_REGS = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [$clog2(N_REGS)-1:0]  regSel,
  input  logic [BUS_W-1:0]           accIn,
  input  logic                       wrLo,
  input  logic                       wrHi,
  input  logic                       rdLo,
  input  logic                       rdHi,
  input  logic                       incReg,
  input  logic                       setPc,
  input  logic                       setIdx,
  input  logic                       fetch,
  input  logic                       idxAccess,
  input  logic                       idxAdvance,
  output logic [BUS_W-1:0]           readByte,
  output logic                       readValid,
  output logic [BUS_W-1:0]           addrOut,
  output logic                       addrHiStb,
  output logic                       addrLoStb,
  output logic                       busy
);

  localparam int SEL_W = $clog2(N_REGS);

  spCtl_t ctl;

  sp_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrLo       (wrLo),
    .wrHi       (wrHi),
    .rdLo       (rdLo),
    .rdHi       (rdHi),
    .incReg     (incReg),
    .setPc      (setPc),
    .setIdx     (setIdx),
    .fetch      (fetch),
    .idxAccess  (idxAccess),
    .idxAdvance (idxAdvance),
    .ctl        (ctl),
    .busy       (busy),
    .addrHiStb  (addrHiStb),
    .addrLoStb  (addrLoStb)
  );

  sp_datapath #(
    .ADDR_W (ADDR_W),
    .BUS_W  (BUS_W),
    .N_REGS (N_REGS),
    .SEL_W  (SEL_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .regSel    (regSel),
    .accIn     (accIn),
    .readByte  (readByte),
    .readValid (readValid),
    .addrOut   (addrOut)
  );

endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrLo,
  input logic             wrHi,
  input logic             rdLo,
  input logic             incReg,
  input logic             fetch,
  input logic             idxAccess,
  input logic [BUS_W-1:0] readByte,
  input logic             readValid,
  input logic [BUS_W-1:0] addrOut,
  input logic             addrHiStb,
  input logic             addrLoStb,
  input logic             busy
);

  p_lo_follows_hi_r4: assert property (@(posedge clk) disable iff (!rstN)
    addrHiStb |=> addrLoStb);

  p_lo_needs_hi_r4: assert property (@(posedge clk) disable iff (!rstN)
    addrLoStb |-> $past(addrHiStb));

  p_fetch_starts_r4: assert property (@(posedge clk) disable iff (!rstN)
    (fetch && !busy) |=> addrHiStb);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (addrOut == '0 && !addrHiStb && !addrLoStb));

  p_busy_ignores_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !readValid);

  p_read_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && rdLo && !fetch && !idxAccess && !wrHi && !wrLo && !incReg) |=> readValid);

  p_byte_held_r3: assert property (@(posedge clk) disable iff (!rstN)
    !readValid |-> $stable(readByte));

endmodule

bind scratchpad_file sp_checker #(.BUS_W(BUS_W)) u_chk (.*);

// File: tb/tb_scratchpad_file.sv
module tb_scratchpad_file;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] regSel = '0;
  logic [7:0] accIn = '0;
  logic wrLo = 0, wrHi = 0, rdLo = 0, rdHi = 0, incReg = 0;
  logic setPc = 0, setIdx = 0, fetch = 0, idxAccess = 0, idxAdvance = 0;
  logic [7:0] readByte, addrOut;
  logic       readValid, addrHiStb, addrLoStb, busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  scratchpad_file dut (.*);

  typedef struct {
    int         kind;   // 0 addr high, 1 addr low, 2 read byte
    logic [7:0] val;
    string      req;
  } expItem_t;

  expItem_t   expQ[$];
  int         testsRun = 0;
  int         testsFailed = 0;
  bit         running = 0;
  bit         finished = 0;
  logic [15:0] mdl [16];
  int         pcS = 0;
  int         idxS = 0;

  task automatic checkVal(string req, logic [15:0] got, logic [15:0] exp, string what);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic pushExp(int kind, logic [7:0] val, string req);
    expItem_t e;
    e.kind = kind; e.val = val; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic checkEvt(int kind, logic [7:0] val);
    expItem_t e;
    testsRun++;
    if (expQ.size() == 0) begin
      testsFailed++;
      $display("FAIL R9 unexpected event kind %0d: actual %h expected none", kind, val);
    end else begin
      e = expQ.pop_front();
      if (e.kind != kind || e.val !== val) begin
        testsFailed++;
        $display("FAIL %s event: actual kind %0d val %h expected kind %0d val %h",
                 e.req, kind, val, e.kind, e.val);
      end
    end
  endtask

  // Monitor: compares outputs against the scoreboard away from the active edge.
  always @(negedge clk) begin
    if (rstN && running) begin
      if (addrHiStb) checkEvt(0, addrOut);
      if (addrLoStb) checkEvt(1, addrOut);
      if (readValid) checkEvt(2, readByte);
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doWrite(bit hi, int sel, logic [7:0] v);
    regSel = 4'(sel); accIn = v;
    if (hi) wrHi = 1; else wrLo = 1;
    step();
    wrHi = 0; wrLo = 0;
    if (hi) mdl[sel][15:8] = v; else mdl[sel][7:0] = v;
  endtask

  task automatic doRead(bit hi, int sel, string req);
    pushExp(2, hi ? mdl[sel][15:8] : mdl[sel][7:0], req);
    regSel = 4'(sel);
    if (hi) rdHi = 1; else rdLo = 1;
    step();
    rdHi = 0; rdLo = 0;
  endtask

  task automatic doFetch(string req);
    pushExp(0, mdl[pcS][15:8], req);
    pushExp(1, mdl[pcS][7:0], req);
    mdl[pcS] = mdl[pcS] + 16'd1;
    fetch = 1;
    step();
    fetch = 0;
    step();
    step();
  endtask

  task automatic doIdx(bit adv, string req);
    pushExp(0, mdl[idxS][15:8], req);
    pushExp(1, mdl[idxS][7:0], req);
    if (adv) mdl[idxS] = mdl[idxS] + 16'd1;
    idxAccess = 1; idxAdvance = adv;
    step();
    idxAccess = 0; idxAdvance = 0;
    step();
    step();
  endtask

  task automatic doInc(int sel);
    regSel = 4'(sel); incReg = 1;
    step();
    incReg = 0;
    mdl[sel] = mdl[sel] + 16'd1;
  endtask

  task automatic doSetPc(int sel);
    regSel = 4'(sel); setPc = 1; step(); setPc = 0; pcS = sel;
  endtask

  task automatic doSetIdx(int sel);
    regSel = 4'(sel); setIdx = 1; step(); setIdx = 0; idxS = sel;
  endtask

  initial begin
    logic [7:0] carried;
    for (int i = 0; i < 16; i++) mdl[i] = 16'h0000;
    repeat (3) @(negedge clk);
    // R1: reset values on the ports while reset is active
    checkVal("R1", 16'(readValid), 16'd0, "readValid in reset");
    checkVal("R1", 16'(busy), 16'd0, "busy in reset");
    rstN = 1;
    @(negedge clk);
    checkVal("R1", 16'(readByte), 16'd0, "readByte after reset");
    checkVal("R1", 16'(addrOut), 16'd0, "addrOut idle");
    checkVal("R1", 16'({addrHiStb, addrLoStb}), 16'd0, "address strobes idle");
    running = 1;

    // R1, R4, R5: fetch from register 0 after reset, then advance
    doFetch("R1");
    doFetch("R5");

    // R2, R3: byte writes keep the other half
    doWrite(1, 3, 8'h12);
    doWrite(0, 3, 8'h34);
    doRead(0, 3, "R3");
    doRead(1, 3, "R3");
    doWrite(0, 3, 8'hAB);
    doRead(1, 3, "R2");
    doRead(0, 3, "R2");

    // R6: program counter moved to register 3
    doSetPc(3);
    doFetch("R6");
    doFetch("R6");

    // R5: wrap at 0xFFFF
    doWrite(1, 5, 8'hFF);
    doWrite(0, 5, 8'hFF);
    doSetPc(5);
    doFetch("R5");
    doFetch("R5");

    // R7: data pointer with and without advance
    doWrite(1, 7, 8'h40);
    doSetIdx(7);
    doIdx(0, "R7");
    doIdx(1, "R7");
    doIdx(0, "R7");

    // R8: direct increment with carry and wrap
    doWrite(0, 9, 8'hFF);
    doInc(9);
    doRead(1, 9, "R8");
    doRead(0, 9, "R8");
    doWrite(1, 9, 8'hFF);
    doWrite(0, 9, 8'hFF);
    doInc(9);
    doRead(1, 9, "R8");
    doRead(0, 9, "R8");

    // R9: strobes during busy are ignored
    pushExp(0, mdl[pcS][15:8], "R4");
    pushExp(1, mdl[pcS][7:0], "R4");
    mdl[pcS] = mdl[pcS] + 16'd1;
    fetch = 1;
    step();
    fetch = 0;
    regSel = 4'd2; accIn = 8'h55; wrLo = 1; rdLo = 1; setPc = 1;
    step();
    wrLo = 0; rdLo = 0; setPc = 0;
    step();
    doRead(0, 2, "R9");
    doFetch("R9");

    // R10: fetch outranks a write; increment outranks a read
    pushExp(0, mdl[pcS][15:8], "R10");
    pushExp(1, mdl[pcS][7:0], "R10");
    mdl[pcS] = mdl[pcS] + 16'd1;
    regSel = 4'd4; accIn = 8'h77; wrLo = 1; fetch = 1;
    step();
    wrLo = 0; fetch = 0;
    step();
    step();
    doRead(0, 4, "R10");
    regSel = 4'd4; incReg = 1; rdLo = 1;
    step();
    incReg = 0; rdLo = 0;
    mdl[4] = mdl[4] + 16'd1;
    doRead(0, 4, "R10");

    // R11: copy register 3 into register 10 through the accumulator
    doRead(0, 3, "R11");
    carried = readByte;
    doWrite(0, 10, carried);
    doRead(1, 3, "R11");
    carried = readByte;
    doWrite(1, 10, carried);
    doRead(0, 10, "R11");
    doRead(1, 10, "R11");

    step();
    step();
    checkVal("R4", 16'(expQ.size()), 16'd0, "pending expected events");
    running = 0;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL R4 watchdog expired: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule